// File: doc/BRIEF.md
# Byte-Lane Writable 16-bit Synchronous RAM

This block gives a 256-word by 16-bit single-port memory in which each byte of a word can be written on its own. Underneath sits one byte-wide storage array with two independent ports. Each 16-bit word takes two adjacent byte locations in that array. The low byte is at the even location and the high byte is at the odd one. The first port always carries the low lane and the second port always carries the high lane, so a full word is read or written in one cycle.

The user drives a word address, write data, a two-bit lane write mask and an enable. The read path is registered, so the storage can map onto on-chip block memory. On any enabled cycle, a lane whose mask bit is clear loads the addressed byte into its output register. A lane whose mask bit is set writes that byte and keeps its last output. When the enable is low, nothing in the block changes.

Top module: `byte_ram16`

## Requirements
- R1: With `rst` high at a rising edge, `dout` is 0x0000 after that edge. Reset does not change stored contents.
- R2: With `cen`=1 and `wen`=2'b00, `dout` after the edge equals the stored word at `addr`. That is one cycle of read latency.
- R3: With `cen`=1 and `wen`=2'b01, bit 0 selects the low lane. `din[7:0]` is stored as the low byte of word `addr`, and the high byte of that word is unchanged.
- R4: With `cen`=1 and `wen`=2'b10, bit 1 selects the high lane. `din[15:8]` is stored as the high byte of word `addr`, and the low byte of that word is unchanged.
- R5: With `cen`=1 and `wen`=2'b11, all 16 bits of `din` are stored at word `addr`.
- R6: In an enabled cycle, a lane being written keeps its previous `dout` byte, while the other lane returns the addressed stored byte (`dout[15:8]` for the high lane, `dout[7:0]` for the low lane).
- R7: With `cen`=0, no byte is written and `dout` holds, whatever `wen`, `addr` and `din` are.
- R8: All 256 words are independent. A write to one word never changes another word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cen | input | 1 | Cycle enable for reads and writes |
| wen | input | 2 | Lane write mask: bit 0 low byte, bit 1 high byte |
| addr | input | 8 | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data |

## Verification
The bench first fills every word and reads every word back. This exposes interleaving faults: a port address that loses or swaps its lane bit makes words alias each other or returns the bytes swapped. It then sweeps all four mask values across every address and compares against a byte-level model. A design that gates both lanes from one mask bit, or rewrites the unselected byte, shows corrupted neighbours on readback. Disabled cycles with active masks check that neither the storage nor `dout` moves. Checks on `dout` during partial writes catch a written lane that wrongly refreshes its output.

// File: rtl/bram_pkg.sv
package bram_pkg;
    parameter int WORD_AW = 8;
    parameter int BYTE_W  = 8;
    parameter int LANES   = 2;
    localparam int LANE_AW = $clog2(LANES);
    localparam int PHYS_AW = WORD_AW + LANE_AW;
    localparam int DATA_W  = BYTE_W * LANES;
    localparam int DEPTH   = 1 << PHYS_AW;

    typedef logic [WORD_AW-1:0] word_addr_t;
    typedef logic [PHYS_AW-1:0] phys_addr_t;
    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [DATA_W-1:0]  word_t;

    typedef struct packed {
        logic       en;
        logic [LANES-1:0] wmask;
        word_addr_t waddr;
        word_t      wdata;
    } user_req_t;

    function automatic phys_addr_t lane_location(word_addr_t w, int lane);
        phys_addr_t p;
        p = {w, LANE_AW'(lane)};
        return p;
    endfunction

    function automatic byte_t lane_slice(word_t d, int lane);
        return d[lane*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/lane_steer.sv
module lane_steer
    import bram_pkg::*;
(
    input  user_req_t                       req,
    output logic      [LANES-1:0]           port_we,
    output phys_addr_t [LANES-1:0]          port_addr,
    output byte_t      [LANES-1:0]          port_wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            port_addr[g]  = lane_location(req.waddr, g);
            port_wdata[g] = lane_slice(req.wdata, g);
            port_we[g]    = req.en & req.wmask[g];
        end
    end
endmodule

// File: rtl/dp_byte_array.sv
module dp_byte_array
    import bram_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic       [LANES-1:0]  we,
    input  phys_addr_t [LANES-1:0]  addr,
    input  byte_t      [LANES-1:0]  wdata,
    output byte_t      [LANES-1:0]  rdata
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < LANES; p++) begin
            if (we[p]) mem[addr[p]] <= wdata[p];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst)                rdata[g] <= '0;
            else if (en && !we[g])  rdata[g] <= mem[addr[g]];
        end

        // R6
        lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (en && we[g]) |=> $stable(rdata[g]));
    end

    // R8
    no_collide_chk: assert property (@(posedge clk) disable iff (rst)
        !(we[0] && we[1] && addr[0] == addr[1]));
endmodule

// File: rtl/byte_ram16.sv
module byte_ram16
    import bram_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cen,
    input  logic [LANES-1:0]   wen,
    input  logic [WORD_AW-1:0] addr,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  dout
);
    user_req_t  req;
    logic       [LANES-1:0] p_we;
    phys_addr_t [LANES-1:0] p_addr;
    byte_t      [LANES-1:0] p_wdata;
    byte_t      [LANES-1:0] p_rdata;

    always_comb begin
        req.en    = cen;
        req.wmask = wen;
        req.waddr = addr;
        req.wdata = din;
    end

    lane_steer i_steer (
        .req        (req),
        .port_we    (p_we),
        .port_addr  (p_addr),
        .port_wdata (p_wdata)
    );

    dp_byte_array i_array (
        .clk   (clk),
        .rst   (rst),
        .en    (cen),
        .we    (p_we),
        .addr  (p_addr),
        .wdata (p_wdata),
        .rdata (p_rdata)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign dout[g*BYTE_W +: BYTE_W] = p_rdata[g];
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cen |=> $stable(dout));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> dout == '0);
endmodule

// File: tb/test_byte_ram16.sv
module test_byte_ram16;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cen = 1'b0;
    logic [1:0]  wen = 2'b00;
    logic [7:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;

    logic [7:0]  ref_lo [256];
    logic [7:0]  ref_hi [256];
    logic [15:0] exp_q = '0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    byte_ram16 i_byte_ram16 (
        .clk(clk), .rst(rst), .cen(cen), .wen(wen),
        .addr(addr), .din(din), .dout(dout)
    );

    task automatic step(input logic r, input logic c, input logic [1:0] w,
                        input logic [7:0] a, input logic [15:0] d, input string tag);
        @(negedge clk);
        rst = r; cen = c; wen = w; addr = a; din = d;
        @(posedge clk);
        #1;
        if (r) exp_q = '0;
        else if (c) begin
            if (w[0]) ref_lo[a] = d[7:0];  else exp_q[7:0]  = ref_lo[a];
            if (w[1]) ref_hi[a] = d[15:8]; else exp_q[15:8] = ref_hi[a];
        end
        total++;
        if (dout !== exp_q) begin
            bad++;
            $display("FAIL %s: addr=%02h dout=%04h expected=%04h", tag, a, dout, exp_q);
        end
    endtask

    function automatic logic [15:0] pat(input int a, input int k);
        return 16'((a * 16'h3b1 + k * 16'h7d) ^ (a << 8) ^ 16'h5ac3);
    endfunction

    function automatic string wtag(input logic [1:0] w);
        case (w)
            2'b00: return "R2";
            2'b01: return "R3 R6";
            2'b10: return "R4 R6";
            default: return "R5 R6";
        endcase
    endfunction

    initial begin
        step(1, 0, 2'b00, 8'h00, 16'h0000, "R1");
        step(1, 0, 2'b11, 8'h10, 16'hffff, "R1");
        // fill every word, full writes
        for (int a = 0; a < 256; a++) step(0, 1, 2'b11, 8'(a), pat(a, 0), "R5 R6");
        // readback of all words: interleaving and independence
        for (int a = 0; a < 256; a++) step(0, 1, 2'b00, 8'(a), 16'h0, "R2 R8");
        // mask sweep, each followed by a readback
        for (int k = 1; k < 4; k++) begin
            for (int a = 0; a < 256; a++) begin
                logic [1:0] w;
                w = 2'((a + k) % 4);
                step(0, 1, w, 8'(a), pat(a, k), wtag(w));
                step(0, 1, 2'b00, 8'(a), 16'h0, (w == 2'b01) ? "R3" : (w == 2'b10) ? "R4" : "R2");
            end
        end
        // disabled cycles must neither write nor move dout
        for (int a = 0; a < 64; a++) step(0, 0, 2'(a % 4), 8'(a * 4), ~pat(a, 9), "R7");
        for (int a = 0; a < 256; a++) step(0, 1, 2'b00, 8'(a), 16'h0, "R7 R8");
        // partial writes back to back at neighbouring words
        for (int a = 0; a < 32; a++) begin
            step(0, 1, 2'b01, 8'(2 * a), pat(a, 11), "R3 R6");
            step(0, 1, 2'b10, 8'(2 * a + 1), pat(a, 12), "R4 R6");
        end
        for (int a = 0; a < 64; a++) step(0, 1, 2'b00, 8'(a), 16'h0, "R8");
        // mid-run reset keeps contents
        step(1, 0, 2'b00, 8'h00, 16'h0, "R1");
        step(0, 1, 2'b00, 8'h05, 16'h0, "R1 R2");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: dout=%04h expected=completion", dout);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule